// File: doc/BRIEF.md
# Single-Cycle 32-bit Load/Store Processor Core

This block is a 32-bit processor core that completes one instruction per clock. Each cycle it presents its program counter as the fetch address, decodes the returned word, reads two operands from a 32-entry register file, runs one ALU operation and then does one of three things: writes a result back, accesses data memory, or redirects the program counter. The register file, the PC and the data-memory write all take effect on the same rising edge.

The instruction set is small: register-to-register add, subtract, AND, OR and signed set-less-than; word load and word store with a 16-bit signed displacement; branch-if-equal; and an absolute jump. Decoding is done in two stages. A main decoder turns the opcode into steering controls and a 2-bit ALU class. A local ALU decoder turns that class, together with the function field, into the 3-bit ALU operation. Instruction and data memories sit outside the core, so the environment can fill them before reset is released. The core drives the PC and each cycle's register-file write (enable, index, value) on ports that a checker can watch.

Top module: `mono_cycle_core`

## Requirements
- R1: While `rst` is high at a rising edge, the PC becomes 0 and every register becomes 0. After reset is released, `pc_o` reads 0 until the first active edge.
- R2: Any instruction other than a taken branch or a jump moves the PC to PC+4 on the next edge.
- R3: Opcode 000000 selects a register operation chosen by bits 5:0: 100000 add, 100010 subtract, 100100 AND, 100101 OR, 101010 signed set-less-than (result 1 or 0). The result is written to the register indexed by bits 15:11.
- R4: Opcode 100011 (load) asserts `dmem_re_o` and drives `dmem_addr_o` with the register at bits 25:21 plus the sign-extended bits 15:0. The value on `dmem_rdata_i` is written to the register indexed by bits 20:16.
- R5: Opcode 101011 (store) asserts `dmem_we_o`, uses the same address as a load, and drives `dmem_wdata_o` with the register at bits 20:16. It writes no register.
- R6: Opcode 000100 (branch) compares the registers at bits 25:21 and 20:16 by subtraction. If they are equal, the next PC is PC+4 plus the sign-extended bits 15:0 shifted left by 2. Otherwise the next PC is PC+4. It writes no register and no memory.
- R7: Opcode 000010 (jump) sets the next PC to bits 31:28 of PC+4, followed by instruction bits 25:0, followed by two zero bits. No register or memory is written.
- R8: Register 0 always reads as 0. An instruction that targets it leaves `rf_we_o` low.
- R9: Any other opcode writes nothing, asserts neither memory strobe, and advances the PC by 4.
- R10: A value written on one edge is visible to the instruction that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| pc_o | output | 32 | Current program counter, used as the instruction fetch address |
| imem_word_i | input | 32 | Instruction word stored at `pc_o` |
| dmem_addr_o | output | 32 | Data memory byte address (ALU result) |
| dmem_wdata_o | output | 32 | Data to store |
| dmem_we_o | output | 1 | Data memory write strobe, taken on the rising edge |
| dmem_re_o | output | 1 | Data memory read request |
| dmem_rdata_i | input | 32 | Combinational data memory read value |
| rf_we_o | output | 1 | A register is written at the next edge |
| rf_waddr_o | output | 5 | Index of the register being written |
| rf_wdata_o | output | 32 | Value being written |

## Verification
On every cycle, the assertions check how the PC follows from the previous cycle: the reset value, the sequential step, the taken-branch target and the jump target. They also check that register 0 reads zero, that a store never coincides with a register write, and that a subtract-class decode reaches the ALU as a subtract. Whether results are correct depends on register contents built up over many instructions, so only the bench's scenarios can show it. These include signed set-less-than, load-after-store through memory, negative displacements, writes aimed at register 0, and illegal opcodes. The bench runs an independent instruction-level model in lockstep and compares the PC and the write ports on every cycle.

// File: rtl/mcc_pkg.sv
package mcc_pkg;
  localparam int XLEN = 32;
  localparam int NREG = 32;
  localparam int RA_W = $clog2(NREG);
  localparam int IMM_W = 16;
  localparam int TGT_W = 26;

  typedef enum logic [5:0] {
    OP_RTYPE = 6'b000000,
    OP_LW    = 6'b100011,
    OP_SW    = 6'b101011,
    OP_BEQ   = 6'b000100,
    OP_J     = 6'b000010
  } opcode_e;

  typedef enum logic [2:0] {
    ALU_AND = 3'b000,
    ALU_OR  = 3'b001,
    ALU_ADD = 3'b010,
    ALU_SUB = 3'b110,
    ALU_SLT = 3'b111
  } alu_ctl_e;

  typedef enum logic [1:0] {
    AOP_ADD   = 2'b00,
    AOP_SUB   = 2'b01,
    AOP_FUNCT = 2'b10
  } alu_op_e;

  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;
  localparam logic [5:0] FN_SLT = 6'b101010;

  typedef struct packed {
    logic    dst_is_rd;
    logic    b_is_imm;
    logic    wb_from_mem;
    logic    reg_write;
    logic    mem_read;
    logic    mem_write;
    logic    branch;
    logic    jump;
    alu_op_e alu_op;
  } ctrl_t;

  function automatic logic [XLEN-1:0] sext16(input logic [IMM_W-1:0] v);
    return {{(XLEN-IMM_W){v[IMM_W-1]}}, v};
  endfunction

  function automatic logic [XLEN-1:0] branch_dest(input logic [XLEN-1:0] pc4,
                                                  input logic [IMM_W-1:0] off);
    return pc4 + (sext16(off) << 2);
  endfunction

  function automatic logic [XLEN-1:0] jump_dest(input logic [XLEN-1:0] pc4,
                                                input logic [TGT_W-1:0] tgt);
    return {pc4[XLEN-1:TGT_W+2], tgt, 2'b00};
  endfunction

  function automatic logic [XLEN-1:0] alu_eval(input alu_ctl_e ctl,
                                               input logic [XLEN-1:0] a,
                                               input logic [XLEN-1:0] b);
    logic [XLEN-1:0] r;
    case (ctl)
      ALU_AND: r = a & b;
      ALU_OR:  r = a | b;
      ALU_ADD: r = a + b;
      ALU_SUB: r = a - b;
      ALU_SLT: r = ($signed(a) < $signed(b)) ? {{(XLEN-1){1'b0}}, 1'b1} : '0;
      default: r = a + b;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/mcc_regbank.sv
module mcc_regbank #(
  parameter int DW = 32,
  parameter int N  = 32,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] raddr_a,
  output logic [DW-1:0] rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [DW-1:0] rdata_b,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata
);
  logic [DW-1:0] mem [N];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) mem[i] <= '0;
    end else if (we && (waddr != '0)) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];

  // R8
  r0_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (raddr_a == '0) |-> (rdata_a == '0));
endmodule

// File: rtl/mcc_main_dec.sv
module mcc_main_dec
  import mcc_pkg::*;
(
  input  logic [5:0] opcode,
  output ctrl_t      ctl
);
  always_comb begin
    ctl = '0;
    ctl.alu_op = AOP_ADD;
    case (opcode)
      OP_RTYPE: begin
        ctl.dst_is_rd = 1'b1;
        ctl.reg_write = 1'b1;
        ctl.alu_op    = AOP_FUNCT;
      end
      OP_LW: begin
        ctl.b_is_imm    = 1'b1;
        ctl.wb_from_mem = 1'b1;
        ctl.reg_write   = 1'b1;
        ctl.mem_read    = 1'b1;
      end
      OP_SW: begin
        ctl.b_is_imm  = 1'b1;
        ctl.mem_write = 1'b1;
      end
      OP_BEQ: begin
        ctl.branch = 1'b1;
        ctl.alu_op = AOP_SUB;
      end
      OP_J: ctl.jump = 1'b1;
      default: ctl.alu_op = AOP_ADD;
    endcase
  end
endmodule

// File: rtl/mcc_alu_dec.sv
module mcc_alu_dec
  import mcc_pkg::*;
(
  input  alu_op_e    op_class,
  input  logic [5:0] funct,
  output alu_ctl_e   alu_ctl
);
  always_comb begin
    case (op_class)
      AOP_ADD: alu_ctl = ALU_ADD;
      AOP_SUB: alu_ctl = ALU_SUB;
      AOP_FUNCT: begin
        case (funct)
          FN_ADD:  alu_ctl = ALU_ADD;
          FN_SUB:  alu_ctl = ALU_SUB;
          FN_AND:  alu_ctl = ALU_AND;
          FN_OR:   alu_ctl = ALU_OR;
          FN_SLT:  alu_ctl = ALU_SLT;
          default: alu_ctl = ALU_ADD;
        endcase
      end
      default: alu_ctl = ALU_ADD;
    endcase
  end
endmodule

// File: rtl/mcc_alu.sv
module mcc_alu
  import mcc_pkg::*;
#(
  parameter int DW = XLEN
) (
  input  alu_ctl_e      ctl,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] y,
  output logic          zero
);
  assign y    = alu_eval(ctl, a, b);
  assign zero = (y == '0);
endmodule

// File: rtl/mono_cycle_core.sv
module mono_cycle_core
  import mcc_pkg::*;
#(
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic        clk,
  input  logic        rst,
  output logic [31:0] pc_o,
  input  logic [31:0] imem_word_i,
  output logic [31:0] dmem_addr_o,
  output logic [31:0] dmem_wdata_o,
  output logic        dmem_we_o,
  output logic        dmem_re_o,
  input  logic [31:0] dmem_rdata_i,
  output logic        rf_we_o,
  output logic [4:0]  rf_waddr_o,
  output logic [31:0] rf_wdata_o
);
  logic [XLEN-1:0] pc_q, pc_next, pc_plus4, branch_target, jump_target;
  logic [5:0]      f_op, f_fn;
  logic [RA_W-1:0] f_rs, f_rt, f_rd, wsel;
  logic [IMM_W-1:0] f_imm;
  logic [TGT_W-1:0] f_tgt;
  ctrl_t           ctl;
  alu_ctl_e        alu_ctl;
  logic [XLEN-1:0] rd_a, rd_b, imm_x, alu_b, alu_y, wb_val;
  logic            alu_zero, take_branch, is_jump, wb_en;

  assign f_op  = imem_word_i[31:26];
  assign f_rs  = imem_word_i[25:21];
  assign f_rt  = imem_word_i[20:16];
  assign f_rd  = imem_word_i[15:11];
  assign f_fn  = imem_word_i[5:0];
  assign f_imm = imem_word_i[15:0];
  assign f_tgt = imem_word_i[25:0];

  mcc_main_dec u_main (.opcode(f_op), .ctl(ctl));
  mcc_alu_dec  u_adec (.op_class(ctl.alu_op), .funct(f_fn), .alu_ctl(alu_ctl));

  mcc_regbank #(.DW(XLEN), .N(NREG)) u_rf (
    .clk(clk), .rst(rst),
    .raddr_a(f_rs), .rdata_a(rd_a),
    .raddr_b(f_rt), .rdata_b(rd_b),
    .we(wb_en), .waddr(wsel), .wdata(wb_val)
  );

  assign imm_x = sext16(f_imm);
  assign alu_b = ctl.b_is_imm ? imm_x : rd_b;

  mcc_alu #(.DW(XLEN)) u_alu (.ctl(alu_ctl), .a(rd_a), .b(alu_b), .y(alu_y), .zero(alu_zero));

  assign wsel   = ctl.dst_is_rd ? f_rd : f_rt;
  assign wb_val = ctl.wb_from_mem ? dmem_rdata_i : alu_y;
  assign wb_en  = ctl.reg_write && (wsel != '0);

  assign pc_plus4      = pc_q + 32'd4;
  assign branch_target = branch_dest(pc_plus4, f_imm);
  assign jump_target   = jump_dest(pc_plus4, f_tgt);
  assign take_branch   = ctl.branch & alu_zero;
  assign is_jump       = ctl.jump;

  always_comb begin
    if (is_jump)          pc_next = jump_target;
    else if (take_branch) pc_next = branch_target;
    else                  pc_next = pc_plus4;
  end

  always_ff @(posedge clk) begin
    if (rst) pc_q <= RESET_PC;
    else     pc_q <= pc_next;
  end

  assign pc_o         = pc_q;
  assign dmem_addr_o  = alu_y;
  assign dmem_wdata_o = rd_b;
  assign dmem_we_o    = ctl.mem_write;
  assign dmem_re_o    = ctl.mem_read;
  assign rf_we_o      = wb_en;
  assign rf_waddr_o   = wsel;
  assign rf_wdata_o   = wb_val;

  // R1
  rst_pc_zero_chk: assert property (@(posedge clk)
    rst |=> (pc_q == RESET_PC));
  // R2
  seq_pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!take_branch && !is_jump) |=> (pc_q == $past(pc_plus4)));
  // R6
  br_taken_pc_chk: assert property (@(posedge clk) disable iff (rst)
    take_branch |=> (pc_q == $past(branch_target)));
  // R7
  jmp_pc_chk: assert property (@(posedge clk) disable iff (rst)
    is_jump |=> (pc_q == $past(jump_target)));
  // R5
  store_no_wb_chk: assert property (@(posedge clk) disable iff (rst)
    dmem_we_o |-> !rf_we_o);
  // R8
  r0_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    rf_we_o |-> (rf_waddr_o != 5'd0));
  // R3
  sub_class_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl.alu_op == AOP_SUB) |-> (alu_ctl == ALU_SUB));
endmodule

// File: tb/sim_mono_cycle_core.sv
module sim_mono_cycle_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] pc_o, imem_word, dmem_addr, dmem_wdata, dmem_rdata, rf_wdata;
  logic        dmem_we, dmem_re, rf_we;
  logic [4:0]  rf_waddr;

  logic [31:0] imem   [64];
  logic [31:0] dmem   [64];
  logic [31:0] dmem_m [64];
  logic [31:0] regs_m [32];
  logic [31:0] pc_m;
  string       pc_tag;
  int          nchk = 0;
  int          nfail = 0;

  always #10 clk = ~clk;

  mono_cycle_core u0 (
    .clk(clk), .rst(rst), .pc_o(pc_o), .imem_word_i(imem_word),
    .dmem_addr_o(dmem_addr), .dmem_wdata_o(dmem_wdata), .dmem_we_o(dmem_we),
    .dmem_re_o(dmem_re), .dmem_rdata_i(dmem_rdata),
    .rf_we_o(rf_we), .rf_waddr_o(rf_waddr), .rf_wdata_o(rf_wdata)
  );

  assign imem_word  = imem[pc_o[7:2]];
  assign dmem_rdata = dmem[dmem_addr[7:2]];
  always @(posedge clk) if (dmem_we && !rst) dmem[dmem_addr[7:2]] <= dmem_wdata;

  function automatic logic [31:0] enc_r(input logic [5:0] fn, input int rs, input int rt, input int rd);
    return {6'b000000, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction
  function automatic logic [31:0] sx(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction
  function automatic logic [31:0] ref_rop(input logic [5:0] fn, input logic [31:0] a, input logic [31:0] b);
    case (fn)
      6'b100000: return a + b;
      6'b100010: return a - b;
      6'b100100: return a & b;
      6'b100101: return a | b;
      6'b101010: return (signed'(a) < signed'(b)) ? 32'd1 : 32'd0;
      default:   return a + b;
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1", "pc after reset", pc_o, 32'h0);
    for (int i = 0; i < 32; i++) regs_m[i] = 32'h0;
    for (int i = 0; i < 64; i++) dmem_m[i] = dmem[i];
    pc_m = 32'h0;
    pc_tag = "R1";
    rst = 1'b0;
  endtask

  task automatic step();
    logic [31:0] ins, a, b, pc4, nxt, res, addr;
    logic [5:0]  op;
    int          rs, rt, rd;
    ins = imem[pc_m[7:2]];
    op = ins[31:26]; rs = int'(ins[25:21]); rt = int'(ins[20:16]); rd = int'(ins[15:11]);
    a = regs_m[rs]; b = regs_m[rt];
    pc4 = pc_m + 32'd4; nxt = pc4;
    chk(pc_tag, "pc", pc_o, pc_m);
    case (op)
      6'b000000: begin
        res = ref_rop(ins[5:0], a, b);
        chk((rd == 0) ? "R8" : "R3", "rf_we", {31'd0, rf_we}, {31'd0, rd != 0});
        if (rd != 0) begin
          chk("R3", "rf_waddr", {27'd0, rf_waddr}, rd);
          chk("R3", "rf_wdata", rf_wdata, res);
          regs_m[rd] = res;
        end
        chk("R3", "dmem_we", {31'd0, dmem_we}, 32'd0);
        pc_tag = "R2";
      end
      6'b100011: begin
        addr = a + sx(ins[15:0]);
        res = dmem_m[addr[7:2]];
        chk("R4", "dmem_re", {31'd0, dmem_re}, 32'd1);
        chk("R4", "dmem_addr", dmem_addr, addr);
        chk((rt == 0) ? "R8" : "R4", "rf_we", {31'd0, rf_we}, {31'd0, rt != 0});
        if (rt != 0) begin
          chk("R4", "rf_waddr", {27'd0, rf_waddr}, rt);
          chk("R4", "rf_wdata", rf_wdata, res);
          regs_m[rt] = res;
        end
        pc_tag = "R2";
      end
      6'b101011: begin
        addr = a + sx(ins[15:0]);
        chk("R5", "dmem_we", {31'd0, dmem_we}, 32'd1);
        chk("R5", "dmem_addr", dmem_addr, addr);
        chk("R5", "dmem_wdata", dmem_wdata, b);
        chk("R5", "rf_we", {31'd0, rf_we}, 32'd0);
        dmem_m[addr[7:2]] = b;
        pc_tag = "R2";
      end
      6'b000100: begin
        if (a == b) nxt = pc4 + (sx(ins[15:0]) << 2);
        chk("R6", "rf_we", {31'd0, rf_we}, 32'd0);
        chk("R6", "dmem_we", {31'd0, dmem_we}, 32'd0);
        pc_tag = "R6";
      end
      6'b000010: begin
        nxt = {pc4[31:28], ins[25:0], 2'b00};
        chk("R7", "rf_we", {31'd0, rf_we}, 32'd0);
        chk("R7", "dmem_we", {31'd0, dmem_we}, 32'd0);
        pc_tag = "R7";
      end
      default: begin
        chk("R9", "rf_we", {31'd0, rf_we}, 32'd0);
        chk("R9", "dmem_we", {31'd0, dmem_we}, 32'd0);
        chk("R9", "dmem_re", {31'd0, dmem_re}, 32'd0);
        pc_tag = "R9";
      end
    endcase
    pc_m = nxt;
    @(negedge clk);
  endtask

  task automatic load_directed();
    for (int i = 0; i < 64; i++) begin imem[i] = 32'h0; dmem[i] = 32'h1000 + i; end
    dmem[0] = 32'h0000_0005;
    dmem[1] = 32'hFFFF_FFF0;
    imem[0]  = enc_i(6'b100011, 0, 1, 16'd0);          // R4 load +5
    imem[1]  = enc_i(6'b100011, 0, 2, 16'd4);          // R4 load -16
    imem[2]  = enc_r(6'b100000, 1, 2, 3);              // R3 add
    imem[3]  = enc_r(6'b100010, 1, 2, 4);              // R3 sub
    imem[4]  = enc_r(6'b100100, 1, 2, 5);              // R3 and
    imem[5]  = enc_r(6'b100101, 1, 2, 6);              // R3 or
    imem[6]  = enc_r(6'b101010, 2, 1, 7);              // R3 slt signed true
    imem[7]  = enc_r(6'b101010, 1, 2, 8);              // R3 slt signed false
    imem[8]  = enc_r(6'b100000, 1, 1, 0);              // R8 write to r0
    imem[9]  = enc_r(6'b100000, 0, 0, 9);              // R8 r0 reads 0
    imem[10] = enc_i(6'b101011, 0, 4, 16'd8);          // R5 store
    imem[11] = enc_i(6'b100011, 0, 10, 16'd8);         // R10 load back
    imem[12] = enc_i(6'b000100, 1, 2, 16'd5);          // R6 not taken
    imem[13] = enc_i(6'b000100, 9, 0, 16'd2);          // R6 taken to 16
    imem[14] = enc_r(6'b100000, 1, 1, 11);
    imem[15] = enc_r(6'b100000, 1, 1, 12);
    imem[16] = enc_i(6'b100011, 13, 12, 16'hFFFC);     // R4 negative offset
    imem[17] = enc_i(6'b001000, 1, 14, 16'd7);         // R9 illegal opcode
    imem[18] = {6'b000010, 26'd20};                    // R7 jump to 80
    imem[19] = enc_r(6'b100000, 1, 1, 15);
    imem[20] = enc_i(6'b000100, 0, 0, 16'hFFFF);       // R6 self loop
  endtask

  task automatic load_random();
    int sel;
    logic [5:0] fns [5];
    logic [5:0] bad [3];
    fns[0] = 6'b100000; fns[1] = 6'b100010; fns[2] = 6'b100100; fns[3] = 6'b100101; fns[4] = 6'b101010;
    bad[0] = 6'b001000; bad[1] = 6'b001111; bad[2] = 6'b111111;
    for (int i = 0; i < 64; i++) begin
      dmem[i] = $urandom;
      sel = int'($urandom % 100);
      if (sel < 50)
        imem[i] = enc_r(fns[$urandom % 5], int'($urandom % 8), int'($urandom % 8), int'($urandom % 8));
      else if (sel < 65)
        imem[i] = enc_i(6'b100011, int'($urandom % 8), int'($urandom % 8), 16'($urandom));
      else if (sel < 80)
        imem[i] = enc_i(6'b101011, int'($urandom % 8), int'($urandom % 8), 16'($urandom));
      else if (sel < 92)
        imem[i] = enc_i(6'b000100, int'($urandom % 8), int'($urandom % 8), 16'(int'($urandom % 17) - 8));
      else if (sel < 96)
        imem[i] = {6'b000010, 26'($urandom)};
      else
        imem[i] = enc_i(bad[$urandom % 3], int'($urandom % 8), int'($urandom % 8), 16'($urandom));
    end
  endtask

  initial begin
    void'($urandom(32'd7731));
    load_directed();
    do_reset();
    for (int c = 0; c < 40; c++) step();
    for (int p = 0; p < 6; p++) begin
      load_random();
      do_reset();
      for (int c = 0; c < 2000; c++) step();
    end
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule